// File: doc/BRIEF.md
# Edge-Triggered Interrupt Aggregator

This block gathers sixteen interrupt event sources into one sticky status view and two latched interrupt request outputs. Two of the sources are encoder count-step pulses that arrive synchronous to the clock. The other fourteen are asynchronous external pins. Each pin has its own enable and its own edge direction. Any qualifying event sets its source's status bit, and the bit holds until software clears it.

Each of the two request outputs, A and B, has a 4-bit selector that picks one of the sixteen sources as its trigger. An output has to be armed before it reacts. Once an armed output fires it stays high until a clear command arrives. All controls, the status, the selectors, the command strobes and the latched output state sit behind a byte-wide register port. Writes take effect at the clock edge. Reads are combinational from the current address.

Top module: `evt_irq_hub`

## Requirements
- R1: External line n (n = 0..13) is controlled by register 1 + n/4. Its enable is at bit 2*(n%4) and its edge select is at bit 2*(n%4)+1. Control bits read back at the same positions, and unused bits read 0. When a line's enable is 0, a transition on that pin raises no event.
- R2: An edge select of 1 makes a rising transition count as the event. An edge select of 0 makes a falling transition count. A transition in the other direction raises no event.
- R3: Register 0 holds encoder enables: bit 0 for encoder 0 and bit 1 for encoder 1. A cycle with `enc_step_i[k]` high raises event source k only while enable k is 1.
- R4: Event sources are numbered as follows: encoders are 0 and 1, and external line n is source n+2. Register 5 reads status bits 7..0 and register 6 reads status bits 15..8. Every event sets its bit at the next clock edge. Events in the same cycle set all of their bits together. Set bits stay set.
- R5: Register 7 holds the selectors: bits 3:0 select the source for A and bits 7:4 select the source for B. After reset the register reads 0xC0, meaning A selects source 0 and B selects source 12.
- R6: Writing register 8 issues commands. Bits 0, 1 and 2 are arm, disarm and clear for A. Bits 3, 4 and 5 are arm, disarm and clear for B. Any combination may be written at once. When arm and disarm are written together, the output ends up disarmed.
- R7: An armed output goes high at the clock edge after its selected source raises an event. It then stays high until a clear command. Reading register 8 returns bit 0 = A high, bit 1 = B high, bit 2 = A armed and bit 3 = B armed.
- R8: External pins pass through a two-stage synchronizer. A single pin transition therefore gives exactly one event. The status bit and any output it triggers change at the third clock edge after the pin changes.
- R9: A clear command for an output also clears the status bit of the source that output currently selects. An event on that source in the same cycle wins, keeping both the status bit and the output set.
- R10: After reset, all enables, the status and the arm state are 0. A disarmed output stays low and ignores its trigger. Disarming drops an output that is already high. The status register keeps updating whatever the arm state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, synchronous to clk |
| enc_step_i | input | 2 | Encoder count-step pulses, one bit per encoder |
| ext_pin_i | input | 14 | Asynchronous external interrupt pins |
| bus_addr_i | input | 4 | Register address |
| bus_wr_i | input | 1 | Write strobe for one cycle |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data for bus_addr_i |
| irq_a_o | output | 1 | Latched request output A |
| irq_b_o | output | 1 | Latched request output B |

## Verification
A corrupted synchronizer or edge history shows up as a missing, doubled or mistimed status bit. That error is visible at the register port on the third edge after the pin moves. A wrong arm or flag state shows at `irq_a_o` or `irq_b_o` and in register 8 within one cycle of the command or trigger that exposes it. A status bit left set or cleared at the wrong time is caught the next time registers 5 and 6 are read. Because the status bits are sticky, such an error persists until an explicit clear.

// File: rtl/evt_irq_pkg.sv
package evt_irq_pkg;

  localparam int unsigned EXT_LINES = 14;
  localparam int unsigned ENC_LINES = 2;
  localparam int unsigned SEL_BITS  = 4;
  localparam int unsigned BUS_BITS  = 8;
  localparam int unsigned ADDR_BITS = 4;

  // one command slice per request output
  typedef struct packed {
    logic arm;
    logic disarm;
    logic clr;
  } irq_cmd_t;

  // true when the synchronized level moved in the chosen direction
  function automatic logic edge_hit(input logic now, input logic was, input logic rising);
    return rising ? (now & ~was) : (~now & was);
  endfunction

  // command slice idx sits at bits 3*idx .. 3*idx+2
  function automatic irq_cmd_t decode_cmd(input logic [BUS_BITS-1:0] b, input int idx);
    irq_cmd_t c;
    c.arm    = b[3*idx];
    c.disarm = b[3*idx+1];
    c.clr    = b[3*idx+2];
    return c;
  endfunction

endpackage

// File: rtl/pin_edge_detect.sv
module pin_edge_detect #(
  parameter int unsigned LINES = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] pin_i,
  input  logic [LINES-1:0] en_i,
  input  logic [LINES-1:0] rise_i,
  output logic [LINES-1:0] evt_o
);
  import evt_irq_pkg::*;

  logic [LINES-1:0] meta_q, sync_q, hist_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
      hist_q <= '0;
    end else begin
      meta_q <= pin_i;
      sync_q <= meta_q;
      hist_q <= sync_q;
    end
  end

  for (genvar i = 0; i < LINES; i++) begin : g_line
    assign evt_o[i] = en_i[i] & edge_hit(sync_q[i], hist_q[i], rise_i[i]);
  end

  // R8: one pin transition yields one event, never two back to back
  assert_one_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_o != '0) |=> ((evt_o & $past(evt_o)) == '0));

  // R1: a disabled line never produces an event
  assert_disabled_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ((evt_o & ~en_i) == '0));

endmodule

// File: rtl/host_regs.sv
module host_regs
  import evt_irq_pkg::*;
#(
  parameter int unsigned N_EXT  = EXT_LINES,
  parameter int unsigned N_ENC  = ENC_LINES,
  parameter int unsigned SEL_W  = SEL_BITS,
  parameter int unsigned DW     = BUS_BITS,
  parameter int unsigned AW     = ADDR_BITS,
  parameter int unsigned SEL_A0 = 0,
  parameter int unsigned SEL_B0 = 12
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [AW-1:0]            addr_i,
  input  logic                     wr_i,
  input  logic [DW-1:0]            wdata_i,
  output logic [DW-1:0]            rdata_o,
  output logic [N_ENC-1:0]         enc_en_o,
  output logic [N_EXT-1:0]         ext_en_o,
  output logic [N_EXT-1:0]         ext_rise_o,
  output logic [1:0][SEL_W-1:0]    sel_o,
  output irq_cmd_t [1:0]           cmd_o,
  input  logic [N_ENC+N_EXT-1:0]   status_i,
  input  logic [1:0]               flag_i,
  input  logic [1:0]               arm_i
);

  localparam int unsigned N_SRC     = N_ENC + N_EXT;
  localparam int unsigned LPR       = DW / 2;
  localparam int unsigned EXT_REGS  = (N_EXT + LPR - 1) / LPR;
  localparam int unsigned STAT_REGS = (N_SRC + DW - 1) / DW;
  localparam int unsigned A_ENC     = 0;
  localparam int unsigned A_EXT0    = 1;
  localparam int unsigned A_STAT0   = A_EXT0 + EXT_REGS;
  localparam int unsigned A_SEL     = A_STAT0 + STAT_REGS;
  localparam int unsigned A_CMD     = A_SEL + 1;

  logic [N_ENC-1:0]      enc_en_q;
  logic [N_EXT-1:0]      en_q, rise_q;
  logic [1:0][SEL_W-1:0] sel_q;
  logic                  wr_enc, wr_sel, wr_cmd;

  assign wr_enc = wr_i && (addr_i == AW'(A_ENC));
  assign wr_sel = wr_i && (addr_i == AW'(A_SEL));
  assign wr_cmd = wr_i && (addr_i == AW'(A_CMD));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      enc_en_q <= '0;
      sel_q[0] <= SEL_W'(SEL_A0);
      sel_q[1] <= SEL_W'(SEL_B0);
    end else begin
      if (wr_enc) enc_en_q <= wdata_i[N_ENC-1:0];
      if (wr_sel) begin
        sel_q[0] <= wdata_i[SEL_W-1:0];
        sel_q[1] <= wdata_i[2*SEL_W-1:SEL_W];
      end
    end
  end

  for (genvar i = 0; i < N_EXT; i++) begin : g_ctl
    localparam int unsigned REG = A_EXT0 + i / LPR;
    localparam int unsigned BIT = 2 * (i % LPR);
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        en_q[i]   <= 1'b0;
        rise_q[i] <= 1'b0;
      end else if (wr_i && addr_i == AW'(REG)) begin
        en_q[i]   <= wdata_i[BIT];
        rise_q[i] <= wdata_i[BIT+1];
      end
    end
  end

  for (genvar j = 0; j < 2; j++) begin : g_cmd
    assign cmd_o[j] = wr_cmd ? decode_cmd(wdata_i, j) : '0;
  end

  assign enc_en_o   = enc_en_q;
  assign ext_en_o   = en_q;
  assign ext_rise_o = rise_q;
  assign sel_o      = sel_q;

  logic [EXT_REGS*LPR-1:0] en_pad, rise_pad;
  logic [STAT_REGS*DW-1:0] stat_pad;

  always_comb begin
    en_pad   = '0;
    rise_pad = '0;
    stat_pad = '0;
    en_pad[N_EXT-1:0]   = en_q;
    rise_pad[N_EXT-1:0] = rise_q;
    stat_pad[N_SRC-1:0] = status_i;
    rdata_o = '0;
    if (addr_i == AW'(A_ENC)) rdata_o[N_ENC-1:0] = enc_en_q;
    for (int r = 0; r < EXT_REGS; r++) begin
      if (addr_i == AW'(A_EXT0 + r)) begin
        for (int k = 0; k < LPR; k++) begin
          rdata_o[2*k]   = en_pad[r*LPR + k];
          rdata_o[2*k+1] = rise_pad[r*LPR + k];
        end
      end
    end
    for (int s = 0; s < STAT_REGS; s++) begin
      if (addr_i == AW'(A_STAT0 + s)) rdata_o = stat_pad[s*DW +: DW];
    end
    if (addr_i == AW'(A_SEL)) rdata_o[2*SEL_W-1:0] = {sel_q[1], sel_q[0]};
    if (addr_i == AW'(A_CMD)) rdata_o[3:0] = {arm_i, flag_i};
  end

  // R5: selectors come out of reset at their defined sources
  assert_sel_reset_R5: assert property (@(posedge clk)
    $rose(rst_n) |-> (sel_q[0] == SEL_W'(SEL_A0) && sel_q[1] == SEL_W'(SEL_B0)));

endmodule

// File: rtl/irq_latch.sv
module irq_latch
  import evt_irq_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  irq_cmd_t cmd_i,
  input  logic     trig_i,
  output logic     flag_o,
  output logic     arm_o
);

  logic arm_q, flag_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      arm_q  <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      if (cmd_i.disarm)   arm_q <= 1'b0;
      else if (cmd_i.arm) arm_q <= 1'b1;

      if (cmd_i.disarm)           flag_q <= 1'b0;
      else if (arm_q && trig_i)   flag_q <= 1'b1;
      else if (cmd_i.clr)         flag_q <= 1'b0;
    end
  end

  assign flag_o = flag_q;
  assign arm_o  = arm_q;

  // R6: disarm wins over a simultaneous arm
  assert_disarm_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_i.arm && cmd_i.disarm) |=> !arm_q);

  // R7: a raised output holds until clear or disarm
  assert_flag_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !cmd_i.clr && !cmd_i.disarm) |=> flag_q);

  // R10: a disarmed output is never high
  assert_disarmed_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !arm_q |-> !flag_q);

  // R9: a trigger in the clear cycle keeps the output up
  assert_trig_beats_clr_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (arm_q && trig_i && !cmd_i.disarm) |=> flag_q);

endmodule

// File: rtl/evt_irq_hub.sv
module evt_irq_hub
  import evt_irq_pkg::*;
#(
  parameter int unsigned N_EXT  = EXT_LINES,
  parameter int unsigned N_ENC  = ENC_LINES,
  parameter int unsigned SEL_W  = SEL_BITS,
  parameter int unsigned DW     = BUS_BITS,
  parameter int unsigned AW     = ADDR_BITS,
  parameter int unsigned SEL_A0 = 0,
  parameter int unsigned SEL_B0 = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_ENC-1:0] enc_step_i,
  input  logic [N_EXT-1:0] ext_pin_i,
  input  logic [AW-1:0]    bus_addr_i,
  input  logic             bus_wr_i,
  input  logic [DW-1:0]    bus_wdata_i,
  output logic [DW-1:0]    bus_rdata_o,
  output logic             irq_a_o,
  output logic             irq_b_o
);

  localparam int unsigned N_SRC = N_ENC + N_EXT;

  logic [N_ENC-1:0]      enc_en;
  logic [N_EXT-1:0]      ext_en, ext_rise, ext_evt;
  logic [1:0][SEL_W-1:0] sel;
  irq_cmd_t [1:0]        cmd;
  logic [N_SRC-1:0]      src_evt, status_q, clr_mask;
  logic [1:0]            trig, flag, arm;

  pin_edge_detect #(.LINES(N_EXT)) u_edge (
    .clk   (clk),
    .rst_n (rst_n),
    .pin_i (ext_pin_i),
    .en_i  (ext_en),
    .rise_i(ext_rise),
    .evt_o (ext_evt)
  );

  host_regs #(
    .N_EXT(N_EXT), .N_ENC(N_ENC), .SEL_W(SEL_W), .DW(DW), .AW(AW),
    .SEL_A0(SEL_A0), .SEL_B0(SEL_B0)
  ) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .addr_i    (bus_addr_i),
    .wr_i      (bus_wr_i),
    .wdata_i   (bus_wdata_i),
    .rdata_o   (bus_rdata_o),
    .enc_en_o  (enc_en),
    .ext_en_o  (ext_en),
    .ext_rise_o(ext_rise),
    .sel_o     (sel),
    .cmd_o     (cmd),
    .status_i  (status_q),
    .flag_i    (flag),
    .arm_i     (arm)
  );

  // source numbering: encoders first, then external lines
  assign src_evt = {ext_evt, enc_step_i & enc_en};

  for (genvar j = 0; j < 2; j++) begin : g_irq
    assign trig[j] = src_evt[sel[j]];
    irq_latch u_latch (
      .clk   (clk),
      .rst_n (rst_n),
      .cmd_i (cmd[j]),
      .trig_i(trig[j]),
      .flag_o(flag[j]),
      .arm_o (arm[j])
    );
  end

  always_comb begin
    clr_mask = '0;
    for (int j = 0; j < 2; j++) begin
      if (cmd[j].clr) clr_mask = clr_mask | (N_SRC'(1) << sel[j]);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) status_q <= '0;
    else        status_q <= (status_q & ~clr_mask) | src_evt;
  end

  assign irq_a_o = flag[0];
  assign irq_b_o = flag[1];

  // R4: every event lands in status at the next edge
  assert_status_sets_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (src_evt != '0) |=> ((status_q & $past(src_evt)) == $past(src_evt)));

  // R4: without a clear, status bits never drop
  assert_status_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!cmd[0].clr && !cmd[1].clr) |=> ((status_q & $past(status_q)) == $past(status_q)));

  // R9: clear drops the selected source's bit when no event competes
  assert_clr_drops_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd[0].clr && !src_evt[sel[0]]) |=> !status_q[$past(sel[0])]);

endmodule

// File: tb/evt_irq_hub_bench.sv
module evt_irq_hub_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  enc_step = '0;
  logic [13:0] ext_pin = '0;
  logic [3:0]  addr = '0;
  logic        wr = 1'b0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata;
  logic        irq_a, irq_b;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  evt_irq_hub u_evt_irq_hub (
    .clk(clk), .rst_n(rst_n), .enc_step_i(enc_step), .ext_pin_i(ext_pin),
    .bus_addr_i(addr), .bus_wr_i(wr), .bus_wdata_i(wdata), .bus_rdata_o(rdata),
    .irq_a_o(irq_a), .irq_b_o(irq_b)
  );

  // line[8:5] en[4] rise[3] from[2] to[1] expect[0]
  localparam logic [8:0] VEC [0:7] = '{
    {4'd0,  1'b1, 1'b1, 1'b0, 1'b1, 1'b1},
    {4'd0,  1'b1, 1'b1, 1'b1, 1'b0, 1'b0},
    {4'd5,  1'b1, 1'b0, 1'b1, 1'b0, 1'b1},
    {4'd5,  1'b1, 1'b0, 1'b0, 1'b1, 1'b0},
    {4'd13, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0},
    {4'd13, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1},
    {4'd9,  1'b0, 1'b0, 1'b1, 1'b0, 1'b0},
    {4'd3,  1'b1, 1'b0, 1'b1, 1'b0, 1'b1}
  };

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr = 1'b1;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; #1; d = rdata;
  endtask

  task automatic rd_status(output logic [15:0] s);
    logic [7:0] lo, hi;
    rd_reg(4'd5, lo);
    rd_reg(4'd6, hi);
    s = {hi, lo};
  endtask

  task automatic wait_cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic step(input logic [1:0] m);
    @(negedge clk); enc_step = m;
    @(negedge clk); enc_step = '0;
  endtask

  // point A at src and clear it: drops that status bit
  task automatic clear_src(input logic [3:0] src);
    wr_reg(4'd7, {4'hC, src});
    wr_reg(4'd8, 8'h04);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [7:0]  d;
    logic [15:0] s;
    wait_cyc(4);
    @(negedge clk); rst_n = 1'b1;

    // reset state
    rd_reg(4'd7, d); chk("R5 selector reset", 16'(d), 16'h00C0);
    rd_status(s);    chk("R10 status reset", s, 16'h0000);
    rd_reg(4'd8, d); chk("R10 arm/flag reset", 16'(d), 16'h0000);
    rd_reg(4'd0, d); chk("R10 encoder enable reset", 16'(d), 16'h0000);
    chk("R10 outputs reset", {14'd0, irq_b, irq_a}, 16'h0000);

    // table of edge cases for external lines
    for (int v = 0; v < 8; v++) begin
      logic [3:0] ln;
      logic [3:0] ra;
      logic [7:0] cb;
      ln = VEC[v][8:5];
      ra = 4'(1 + ln / 4);
      cb = 8'(({VEC[v][3], VEC[v][4]}) << (2 * (ln % 4)));
      wr_reg(ra, 8'h00);
      @(negedge clk); ext_pin[ln] = VEC[v][2];
      wait_cyc(4);
      clear_src(4'(ln + 2));
      wr_reg(ra, cb);
      rd_reg(ra, d); chk("R1 control readback", 16'(d), 16'(cb));
      @(negedge clk); ext_pin[ln] = VEC[v][1];
      wait_cyc(4);
      rd_status(s);
      chk(VEC[v][4] ? "R2 edge direction" : "R1 disabled line", s,
          VEC[v][0] ? (16'd1 << (ln + 2)) : 16'd0);
      clear_src(4'(ln + 2));
      wr_reg(ra, 8'h00);
    end

    // encoders
    wr_reg(4'd0, 8'h01);
    step(2'b10);
    rd_status(s); chk("R3 disabled encoder ignored", s, 16'h0000);
    wr_reg(4'd0, 8'h03);
    step(2'b11);
    rd_status(s); chk("R4 simultaneous events", s, 16'h0003);
    wait_cyc(3);
    rd_status(s); chk("R4 status sticky", s, 16'h0003);
    clear_src(4'd0); clear_src(4'd1);
    rd_status(s); chk("R9 clear drops selected bits", s, 16'h0000);

    // B on default source 12 = line 10 rising; latency
    wr_reg(4'd7, 8'hC0);
    wr_reg(4'd8, 8'h08);
    wr_reg(4'd3, 8'h30);
    @(negedge clk); ext_pin[10] = 1'b1;
    @(negedge clk); chk("R8 no output after edge 1", 16'(irq_b), 16'd0);
    @(negedge clk); chk("R8 no output after edge 2", 16'(irq_b), 16'd0);
    @(negedge clk); chk("R8 output after edge 3", 16'(irq_b), 16'd1);
    rd_status(s); chk("R8 status bit 12", s, 16'h1000);
    wr_reg(4'd8, 8'h20);
    chk("R7 clear drops B", 16'(irq_b), 16'd0);
    wait_cyc(5);
    rd_status(s); chk("R8 single event per transition", s, 16'h0000);
    chk("R8 B stays low", 16'(irq_b), 16'd0);

    // A on encoder 0
    wr_reg(4'd8, 8'h01);
    step(2'b01);
    chk("R7 A raised", 16'(irq_a), 16'd1);
    wait_cyc(5);
    chk("R7 A holds", 16'(irq_a), 16'd1);
    rd_reg(4'd8, d); chk("R7 readback", 16'(d), 16'h000D);
    @(negedge clk); addr = 4'd8; wdata = 8'h04; wr = 1'b1; enc_step = 2'b01;
    @(negedge clk); wr = 1'b0; enc_step = '0;
    chk("R9 event beats clear on output", 16'(irq_a), 16'd1);
    rd_status(s); chk("R9 event beats clear on status", s, 16'h0001);
    wr_reg(4'd8, 8'h04);
    chk("R9 clear alone", 16'(irq_a), 16'd0);
    rd_status(s); chk("R9 status cleared", s, 16'h0000);

    // arm and disarm together
    wr_reg(4'd8, 8'h03);
    rd_reg(4'd8, d); chk("R6 disarm wins", 16'(d), 16'h0008);
    step(2'b01);
    chk("R10 disarmed ignores trigger", 16'(irq_a), 16'd0);
    rd_status(s); chk("R10 status still updates", s, 16'h0001);
    clear_src(4'd0);
    wr_reg(4'd8, 8'h01);
    step(2'b01);
    wr_reg(4'd8, 8'h02);
    chk("R10 disarm drops output", 16'(irq_a), 16'd0);
    wr_reg(4'd8, 8'h01);
    chk("R10 rearm keeps low", 16'(irq_a), 16'd0);
    wr_reg(4'd8, 8'h12);
    rd_reg(4'd8, d); chk("R6 several commands at once", 16'(d), 16'h0000);
    wr_reg(4'd8, 8'h09);
    rd_reg(4'd8, d); chk("R6 arm both at once", 16'(d), 16'h000C);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule